// File: doc/BRIEF.md
# Prescaled PWM Channel with Double-Buffered Duty

This block is one pulse-width modulation channel. An 8-bit free-running counter advances once per prescaler tick. The prescaler divides the system clock by a power of two chosen by a 4-bit field. The output goes high when the counter wraps to zero. It goes low once the counter is strictly greater than the active duty value. Behind an external low-pass filter the output serves as a coarse digital-to-analog converter. Without the filter it serves as a control signal.

Software writes the duty value through a one-cycle write strobe into a holding register. The comparator never reads the holding register directly. The holding value is copied into the active register only at the counter wrap, so each period runs on one consistent duty value. The divide field has its own write strobe, and writing it restarts the prescale count. Several identical channels may be placed side by side; each keeps its own state.

Top module: `pwm_chan`

## Requirements
- R1: A synchronous active-high reset clears the counter, the prescaler, the divide field, both duty registers and the output. An enabled channel after reset therefore behaves as duty 0 with divide 1.
- R2: With divide field N (4 bits, unsigned), the counter advances once every 2^N clock cycles. One full period lasts 256 * 2^N cycles.
- R3: While enabled, the output is high for counter values not greater than the active duty value and low for greater ones. Per period it is high for (duty+1) * 2^N cycles when duty < 255.
- R4: With active duty 255 the output stays high for the whole period and never clears.
- R5: With active duty 0 the output is high only while the counter is 0, for 2^N cycles per period.
- R6: A duty write only changes the holding register. The active register takes the holding value at the counter wrap (255 to 0), and the period in progress keeps its duty. A write in the wrap cycle applies to the new period.
- R7: While enable is low, the counter and prescaler are held at zero and the output is low one cycle later. On the first clock edge with enable high, the counter starts at 0 and the output goes high.
- R8: A divide-field write clears the prescale count. The next counter advance comes 2^N cycles after the write edge, where N is the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel run enable |
| wr_width | input | 1 | One-cycle strobe that writes width_in into the holding duty register |
| width_in | input | 8 | New duty value |
| wr_div | input | 1 | One-cycle strobe that writes div_in into the divide field |
| div_in | input | 4 | New divide exponent N (divide by 2^N) |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench builds the channel with its default parameters: an 8-bit counter and a 4-bit divide field. With these values a full period at divide exponents 0 to 2 fits in a few hundred to about a thousand cycles. Whole periods are therefore measured edge to edge, including the duty extremes 0 and 255. The mid-period duty rewrite and the prescale restart at exponent 3 are driven as directed sequences. The random phase keeps exponents small so that many wraps, and with them many duty swaps, fall inside the run.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PWM_CNT_W_DEF = 8;
    localparam int PWM_DIV_W_DEF = 4;

    // Per-cycle events that steer the channel datapath.
    typedef struct packed {
        logic adv;   // counter may advance this cycle
        logic tick;  // prescaler expires: counter advances
        logic wrap;  // counter rolls over to zero
        logic load;  // active duty takes the holding value
    } pwm_evt_t;

    // Width of the prescale counter that can count up to 2^(2^div_w - 1) - 1.
    function automatic int pre_bits(input int div_w);
        return (1 << div_w) - 1;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int DIV_W = PWM_DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             adv,
    input  logic             wr_div,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    localparam int PRE_W = pre_bits(DIV_W);

    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Terminal count for divide by 2^div_q: the low div_q bits all set.
    assign limit = ~({PRE_W{1'b1}} << div_q);
    assign tick  = adv && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            pre_q <= '0;
        end else begin
            if (wr_div) begin
                div_q <= div_in;
            end
            if (!en || wr_div || tick) begin
                pre_q <= '0;
            end else if (adv) begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R2: the prescale count never passes the terminal count of the current divide.
    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (rst)
        pre_q <= limit);

    // R8: a divide write restarts the prescale count.
    assert_pre_restart_R8: assert property (@(posedge clk) disable iff (rst)
        wr_div |=> (pre_q == '0));

endmodule

// File: rtl/pwm_duty_regs.sv
module pwm_duty_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             load,
    output logic [CNT_W-1:0] act_q,
    output logic [CNT_W-1:0] act_d
);
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] hold_d;

    assign hold_d = wr ? wdata : hold_q;
    assign act_d  = load ? hold_d : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            hold_q <= hold_d;
            act_q  <= act_d;
        end
    end

    // R6: a write outside the load point leaves the active duty untouched.
    assert_write_isolated_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && !load) |=> (act_q == $past(act_q)));

endmodule

// File: rtl/pwm_count_cmp.sv
module pwm_count_cmp
    import pwm_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] act_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_top,
    output logic             out_q
);
    logic [CNT_W-1:0] cnt_d;

    assign at_top = (cnt_q == {CNT_W{1'b1}});

    always_comb begin
        if (!en) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            out_q <= en && (cnt_d <= act_d);
        end
    end

    // R2: while running, the counter moves by at most one step per cycle.
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(en, 2)) |->
            ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W_DEF,
    parameter int DIV_W = PWM_DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_width,
    input  logic [CNT_W-1:0] width_in,
    input  logic             wr_div,
    input  logic [DIV_W-1:0] div_in,
    output logic             pwm_out
);
    pwm_evt_t         evt;
    logic             run_q;
    logic             tick;
    logic             at_top;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] act_d;

    // The first enabled edge only starts the period; advancing begins after it.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            run_q <= en;
        end
    end

    always_comb begin
        evt.adv  = run_q && en && !wr_div;
        evt.tick = tick;
        evt.wrap = tick && at_top;
        evt.load = !en || !run_q || evt.wrap;
    end

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .adv    (evt.adv),
        .wr_div (wr_div),
        .div_in (div_in),
        .tick   (tick)
    );

    pwm_duty_regs #(.CNT_W(CNT_W)) u_duty (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_width),
        .wdata (width_in),
        .load  (evt.load),
        .act_q (act_q),
        .act_d (act_d)
    );

    pwm_count_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (evt.tick),
        .act_d  (act_d),
        .cnt_q  (cnt_q),
        .at_top (at_top),
        .out_q  (pwm_out)
    );

    // R7: disabling parks the counter at zero and drives the output low.
    assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pwm_out && (cnt_q == '0)));

    // R7: the first enabled edge opens a period with the output high.
    assert_start_high_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !run_q) |=> pwm_out);

    // R3: a falling output while running means the count passed the duty.
    assert_fall_exceeds_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_out) && $past(en)) |-> (cnt_q > act_q));

    // R4: full-scale duty keeps the output high.
    assert_full_high_R4: assert property (@(posedge clk) disable iff (rst)
        (en && run_q && (act_d == {CNT_W{1'b1}})) |=> pwm_out);

    // R6: while running, the active duty only changes as the counter lands on zero.
    assert_swap_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(run_q) && (act_q != $past(act_q))) |-> (cnt_q == '0));

endmodule

// File: tb/sim_pwm_chan.sv
module sim_pwm_chan;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       wr_width = 1'b0;
    logic [7:0] width_in = '0;
    logic       wr_div = 1'b0;
    logic [3:0] div_in = '0;
    logic       pwm_out;

    int checks = 0;
    int errs   = 0;
    logic model_on = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_chan u0 (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .wr_width (wr_width),
        .width_in (width_in),
        .wr_div   (wr_div),
        .div_in   (div_in),
        .pwm_out  (pwm_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle model of the requirements.
    int m_run, m_pre, m_div, m_cnt, m_hold, m_act, m_out;
    int b_hd, b_adv, b_tk, b_ld, b_nc, b_na;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_pre = 0; m_div = 0; m_cnt = 0;
            m_hold = 0; m_act = 0; m_out = 0;
        end else begin
            b_hd  = wr_width ? int'(width_in) : m_hold;
            b_adv = (m_run != 0 && en && !wr_div) ? 1 : 0;
            b_tk  = (b_adv != 0 && m_pre == ((1 << m_div) - 1)) ? 1 : 0;
            b_ld  = (!en || m_run == 0 || (b_tk != 0 && m_cnt == 255)) ? 1 : 0;
            b_nc  = !en ? 0 : (b_tk != 0 ? (m_cnt + 1) % 256 : m_cnt);
            b_na  = (b_ld != 0) ? b_hd : m_act;
            if (!en || wr_div || b_tk != 0) m_pre = 0;
            else if (b_adv != 0) m_pre = m_pre + 1;
            if (wr_div) m_div = int'(div_in);
            m_out  = (en && b_nc <= b_na) ? 1 : 0;
            m_cnt  = b_nc;
            m_act  = b_na;
            m_hold = b_hd;
            m_run  = en ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check(int'(pwm_out) == m_out, "R3 cycle model", int'(pwm_out), m_out);
        end
    end

    // Load duty w and exponent n while idle, enable, and measure one period.
    task automatic measure(input int w, input int n);
        int p;
        int highs;
        int exp_h;
        logic last;
        @(negedge clk);
        en = 1'b0; wr_width = 1'b1; width_in = 8'(w); wr_div = 1'b1; div_in = 4'(n);
        @(negedge clk);
        wr_width = 1'b0; wr_div = 1'b0;
        @(negedge clk);
        en = 1'b1;
        p = 256 << n;
        highs = 0;
        last = 1'b0;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            last = pwm_out;
        end
        exp_h = (w == 255) ? p : ((w + 1) << n);
        if (w == 255)
            check(highs == exp_h, "R4 full duty high count", highs, exp_h);
        else if (w == 0)
            check(highs == exp_h, "R5 zero duty high count", highs, exp_h);
        else
            check(highs == exp_h, "R3 high count per period", highs, exp_h);
        if (w != 255)
            check(last == 1'b0, "R2 period end low", int'(last), 0);
        @(negedge clk);
        check(pwm_out == 1'b1, "R2 next period starts high", int'(pwm_out), 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1 output low in reset", int'(pwm_out), 0);
        en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_on = 1'b1;
        // R1: cleared duty and divide: one high cycle at count 0, then low.
        @(negedge clk);
        check(pwm_out == 1'b1, "R1 first count after reset high", int'(pwm_out), 1);
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 cleared duty low at count 1", int'(pwm_out), 0);

        measure(0, 0);
        measure(0, 2);
        measure(128, 0);
        measure(77, 1);
        measure(255, 1);
        measure(254, 0);

        // R6: rewrite duty mid-period.
        @(negedge clk);
        en = 1'b0; wr_width = 1'b1; width_in = 8'd200; wr_div = 1'b1; div_in = 4'd0;
        @(negedge clk);
        wr_width = 1'b0; wr_div = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (11) @(negedge clk);
        wr_width = 1'b1; width_in = 8'd10;
        @(negedge clk);
        wr_width = 1'b0;
        repeat (99) @(negedge clk);
        check(pwm_out == 1'b1, "R6 current period keeps old duty", int'(pwm_out), 1);
        begin
            int guard = 0;
            int highs = 0;
            while (pwm_out && guard < 400) begin @(negedge clk); guard++; end
            while (!pwm_out && guard < 400) begin @(negedge clk); guard++; end
            while (pwm_out && guard < 800) begin @(negedge clk); guard++; highs++; end
            check(highs == 11, "R6 next period uses new duty", highs, 11);
        end

        // R7: drop enable mid-run, then restart.
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0, "R7 disabled output low", int'(pwm_out), 0);
        repeat (4) @(negedge clk);
        check(pwm_out == 1'b0, "R7 stays low while disabled", int'(pwm_out), 0);
        en = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b1, "R7 enable starts high", int'(pwm_out), 1);

        // R8: rewrite divide exponent 3 five cycles into count 0.
        @(negedge clk);
        en = 1'b0; wr_width = 1'b1; width_in = 8'd0; wr_div = 1'b1; div_in = 4'd3;
        @(negedge clk);
        wr_width = 1'b0; wr_div = 1'b0;
        @(negedge clk);
        en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 13) check(pwm_out == 1'b1, "R8 restart delays advance", int'(pwm_out), 1);
            if (i == 14) check(pwm_out == 1'b0, "R8 advance after 2^N from write", int'(pwm_out), 0);
            if (i == 5) begin wr_div = 1'b1; div_in = 4'd3; end
            else wr_div = 1'b0;
        end

        // Random phase against the cycle model.
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            wr_width = ($urandom % 30) == 0;
            width_in = 8'($urandom);
            if (($urandom % 8) == 0) width_in = (($urandom % 2) == 0) ? 8'd0 : 8'd255;
            wr_div = ($urandom % 400) == 0;
            div_in = 4'($urandom % 3);
            if (($urandom % 700) == 0) en = ~en;
        end
        @(negedge clk);
        wr_width = 1'b0; wr_div = 1'b0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule